// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Code Bank

This block keeps the digital codes for four DAC channels. Each channel owns two stages: a staging (input) register that an upstream serial-word decoder fills, and an output (DAC) register whose contents drive the converter. A word is committed when the decoder raises its word-valid strobe during the cycle that carries the byte-complete pulse; bits 15:14 of the word pick the channel.

The load control `ldac_n` moves staged codes into the output stage. In asynchronous mode a falling edge of `ldac_n` moves every channel that has been rewritten since its last move. In synchronous mode a committed word goes straight to the output stage while `ldac_n` is low, and any pending channel moves on every cycle in which `ldac_n` is low. A channel whose staging register has not been rewritten is never moved. This avoids needless output activity. The gain and buffer control bits travel with the code through both stages.

A power-down pin and a per-channel active-low power-down bit in each word decide whether a channel output is driven or left high-impedance. Register contents survive power-down, and writes and moves still take place while powered down.

Top module: `dac_bank`

## Requirements
- R1: After reset every output code, gain bit and buffer bit reads 0, every `out_en` bit reads 0 (the stored power-down bit is 0), and the block starts in asynchronous mode.
- R2: A word is committed only in a cycle where `wr_valid` and `byte_tick` are both 1. A `wr_valid` without `byte_tick` changes no staged or output state.
- R3: In asynchronous mode (`sync_mode` 0), a committed word changes no output code, gain or buffer bit, whatever the level of `ldac_n`, until the next falling edge of `ldac_n`.
- R4: In asynchronous mode, the clock edge at which `ldac_n` is first sampled low after being high copies every rewritten channel's staged word to its output, all in the same edge.
- R5: A channel that has not been rewritten since its last move keeps its output word across a move of other channels.
- R6: In synchronous mode (`sync_mode` 1, taking effect one edge after it is driven), a word committed while `ldac_n` is low appears on that channel's outputs at the commit edge.
- R7: In synchronous mode, a word committed while `ldac_n` is high is held, and moves at the first edge where `ldac_n` is sampled low.
- R8: The word fields are: bits 15:14 channel, bit 13 gain, bit 12 active-low power-down, bits 11:2 the 10-bit code, bit 1 buffer enable. Code, gain, buffer and power-down bits all pass through both stages together.
- R9: `out_en[i]` is 1 only when `pd_n` is 1 and channel i's output-stage power-down bit is 1. It follows `pd_n` without a clock edge.
- R10: While powered down, commits and moves still update the codes, and on leaving power-down the current output codes are presented at once.
- R11: In asynchronous mode, if a channel is committed in the same edge as a falling `ldac_n`, the output takes the previously staged word and the new word stays pending until the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | Decoder word-valid strobe |
| byte_tick | input | 1 | Pulse marking the byte-complete clock edge |
| wr_data | input | 16 | Serial data word (fields per R8) |
| ldac_n | input | 1 | Active-low load control |
| sync_mode | input | 1 | 1 selects synchronous load, 0 asynchronous |
| pd_n | input | 1 | Active-low power-down pin |
| dac_code | output | 40 | Output-stage codes, channel i at bits 10*i+9:10*i |
| dac_gain | output | 4 | Output-stage gain bits |
| dac_buf | output | 4 | Output-stage buffer enable bits |
| out_en | output | 4 | 1 drives the channel output, 0 leaves it high-impedance |

## Verification
Commits, moves and mode changes are registered once, so their effect is due in the cycle after the edge that samples the stimulus. The bench drives one nanosecond after each rising edge and compares every channel one nanosecond after the following edge. `out_en` responds to `pd_n` with no register, so after a `pd_n` change the bench checks it one nanosecond later without waiting for an edge. Expected words come from a per-channel staging/pending/output model that the bench updates once for each edge, following the requirement rules.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  localparam int WORD_W   = 16;
  localparam int CH_LSB   = 14;
  localparam int GAIN_BIT = 13;
  localparam int PDN_BIT  = 12;
  localparam int CODE_MSB = 11;
  localparam int BUF_BIT  = 1;

  typedef struct packed {
    logic gain;
    logic bufen;
    logic pd_n;
  } ctl_t;
endpackage

// File: rtl/dac_bank_ldac_ctl.sv
module dac_bank_ldac_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ldac_n,
  input  logic sync_mode,
  output logic mode_q,
  output logic ldac_q,
  output logic xfer_go,
  output logic direct
);
  logic fall;

  always_comb begin
    fall    = ldac_q & ~ldac_n;
    xfer_go = mode_q ? ~ldac_n : fall;
    direct  = mode_q & ~ldac_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      ldac_q <= 1'b1;
    end else begin
      mode_q <= sync_mode;
      ldac_q <= ldac_n;
    end
  end
endmodule

// File: rtl/dac_bank_chan.sv
module dac_bank_chan
  import dac_bank_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic              direct,
  input  logic              xfer_go,
  input  logic [CODE_W-1:0] wr_code,
  input  ctl_t              wr_ctl,
  output logic [CODE_W-1:0] dac_code,
  output ctl_t              dac_ctl
);
  logic [CODE_W-1:0] in_code_q, in_code_d, dac_code_d;
  ctl_t              in_ctl_q, in_ctl_d, dac_ctl_d;
  logic              dirty_q, dirty_d;
  logic              in_en, dac_en, xfer;

  always_comb begin
    xfer       = xfer_go & dirty_q;
    in_en      = wr_hit;
    dac_en     = 1'b0;
    in_code_d  = wr_code;
    in_ctl_d   = wr_ctl;
    dac_code_d = dac_code;
    dac_ctl_d  = dac_ctl;
    dirty_d    = dirty_q;
    if (wr_hit && direct) begin
      dac_en     = 1'b1;
      dac_code_d = wr_code;
      dac_ctl_d  = wr_ctl;
      dirty_d    = 1'b0;
    end else begin
      if (xfer) begin
        dac_en     = 1'b1;
        dac_code_d = in_code_q;
        dac_ctl_d  = in_ctl_q;
        dirty_d    = 1'b0;
      end
      if (wr_hit) dirty_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_code_q <= '0;
      in_ctl_q  <= '0;
      dac_code  <= '0;
      dac_ctl   <= '0;
      dirty_q   <= 1'b0;
    end else begin
      if (in_en) begin
        in_code_q <= in_code_d;
        in_ctl_q  <= in_ctl_d;
      end
      if (dac_en) begin
        dac_code <= dac_code_d;
        dac_ctl  <= dac_ctl_d;
      end
      dirty_q <= dirty_d;
    end
  end
endmodule

// File: rtl/dac_bank.sv
module dac_bank
  import dac_bank_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CODE_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  input  logic                  byte_tick,
  input  logic [WORD_W-1:0]     wr_data,
  input  logic                  ldac_n,
  input  logic                  sync_mode,
  input  logic                  pd_n,
  output logic [NCH*CODE_W-1:0] dac_code,
  output logic [NCH-1:0]        dac_gain,
  output logic [NCH-1:0]        dac_buf,
  output logic [NCH-1:0]        out_en
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic            rs_meta, rs_n;
  logic            mode_q, ldac_q, xfer_go, direct, commit;
  logic [CH_W-1:0] wr_ch;
  ctl_t            wr_ctl;
  logic [CODE_W-1:0] wr_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  always_comb begin
    commit       = wr_valid & byte_tick;
    wr_ch        = wr_data[CH_LSB +: CH_W];
    wr_code      = wr_data[CODE_MSB -: CODE_W];
    wr_ctl.gain  = wr_data[GAIN_BIT];
    wr_ctl.bufen = wr_data[BUF_BIT];
    wr_ctl.pd_n  = wr_data[PDN_BIT];
  end

  dac_bank_ldac_ctl ldac_i (
    .clk(clk), .rst_n(rs_n), .ldac_n(ldac_n), .sync_mode(sync_mode),
    .mode_q(mode_q), .ldac_q(ldac_q), .xfer_go(xfer_go), .direct(direct)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ctl_t ctl_o;
    logic hit;
    assign hit = commit & (wr_ch == CH_W'(i));
    dac_bank_chan #(.CODE_W(CODE_W)) chan_i (
      .clk(clk), .rst_n(rs_n), .wr_hit(hit), .direct(direct),
      .xfer_go(xfer_go), .wr_code(wr_code), .wr_ctl(wr_ctl),
      .dac_code(dac_code[i*CODE_W +: CODE_W]), .dac_ctl(ctl_o)
    );
    assign dac_gain[i] = ctl_o.gain;
    assign dac_buf[i]  = ctl_o.bufen;
    assign out_en[i]   = pd_n & ctl_o.pd_n;
  end
endmodule

// File: rtl/dac_bank_chk.sv
module dac_bank_chk #(
  parameter int NCH    = 4,
  parameter int CODE_W = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rs_n,
  input logic                  mode_q,
  input logic                  ldac_q,
  input logic                  wr_valid,
  input logic                  byte_tick,
  input logic [15:0]           wr_data,
  input logic                  ldac_n,
  input logic                  pd_n,
  input logic [NCH*CODE_W-1:0] dac_code,
  input logic [NCH-1:0]        out_en
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_n |-> (dac_code == '0 && out_en == '0));

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_n && ldac_n && ldac_q && !(wr_valid && byte_tick)) |=> $stable(dac_code));

  a_r3_async_no_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_n && !mode_q && !(ldac_q && !ldac_n)) |=> $stable(dac_code));

  a_r6_sync_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_n && mode_q && !ldac_n && wr_valid && byte_tick) |=>
      dac_code[$past(wr_data[15:14])*CODE_W +: CODE_W] == $past(wr_data[11:2]));

  a_r9_pin_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |-> out_en == '0);
endmodule

bind dac_bank dac_bank_chk #(.NCH(NCH), .CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rs_n(rs_n), .mode_q(mode_q), .ldac_q(ldac_q),
  .wr_valid(wr_valid), .byte_tick(byte_tick), .wr_data(wr_data),
  .ldac_n(ldac_n), .pd_n(pd_n), .dac_code(dac_code), .out_en(out_en)
);

// File: tb/dac_bank_tb.sv
`timescale 1ns/1ps
module dac_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, wr_valid, byte_tick, ldac_n, sync_mode, pd_n;
  logic [15:0] wr_data;
  logic [39:0] dac_code;
  logic [3:0]  dac_gain, dac_buf, out_en;

  int checks = 0, errors = 0;
  logic        finished = 1'b0;

  // model words: {gain, buf, pd_n, code[9:0]}
  logic [12:0] m_in[4], m_dac[4];
  logic        m_dirty[4];
  logic        m_mode, m_ldq;

  always #5 clk = ~clk;

  dac_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .byte_tick(byte_tick),
    .wr_data(wr_data), .ldac_n(ldac_n), .sync_mode(sync_mode), .pd_n(pd_n),
    .dac_code(dac_code), .dac_gain(dac_gain), .dac_buf(dac_buf), .out_en(out_en)
  );

  function automatic logic [12:0] unpack_word(logic [15:0] w);
    return {w[13], w[1], w[12], w[11:2]};
  endfunction

  task automatic model_edge();
    logic fall, com;
    logic [1:0] ch;
    fall = m_ldq & ~ldac_n;
    com  = wr_valid & byte_tick;
    ch   = wr_data[15:14];
    for (int i = 0; i < 4; i++) begin
      logic hit, xf;
      hit = com && (ch == 2'(i));
      xf  = m_dirty[i] && (m_mode ? ~ldac_n : fall);
      if (hit && m_mode && !ldac_n) begin
        m_in[i] = unpack_word(wr_data); m_dac[i] = unpack_word(wr_data); m_dirty[i] = 1'b0;
      end else begin
        if (xf) begin m_dac[i] = m_in[i]; m_dirty[i] = 1'b0; end
        if (hit) begin m_in[i] = unpack_word(wr_data); m_dirty[i] = 1'b1; end
      end
    end
    m_mode = sync_mode;
    m_ldq  = ldac_n;
  endtask

  task automatic step();
    model_edge();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag);
    for (int i = 0; i < 4; i++) begin
      logic [12:0] act;
      logic        en_exp;
      act    = {dac_gain[i], dac_buf[i], out_en[i], dac_code[i*10 +: 10]};
      en_exp = pd_n & m_dac[i][10];
      checks++;
      if (act[9:0] !== m_dac[i][9:0] || act[12] !== m_dac[i][12] ||
          act[11] !== m_dac[i][11] || act[10] !== en_exp) begin
        errors++;
        $display("FAIL %s ch%0d: actual gain/buf/en/code=%b/%b/%b/%h expected %b/%b/%b/%h",
                 tag, i, act[12], act[11], act[10], act[9:0],
                 m_dac[i][12], m_dac[i][11], en_exp, m_dac[i][9:0]);
      end
    end
  endtask

  task automatic wr(int ch, int code, bit g, bit b, bit pdn, bit tick);
    wr_data   = {2'(ch), g, pdn, 10'(code), b, 1'b0};
    wr_valid  = 1'b1;
    byte_tick = tick;
    step();
    wr_valid  = 1'b0;
    byte_tick = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; byte_tick = 1'b0; wr_data = '0;
    ldac_n = 1'b1; sync_mode = 1'b0; pd_n = 1'b1;
    for (int i = 0; i < 4; i++) begin m_in[i] = '0; m_dac[i] = '0; m_dirty[i] = 1'b0; end
    m_mode = 1'b0; m_ldq = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 literal reset state
    checks++;
    if (dac_code !== '0 || out_en !== '0 || dac_gain !== '0 || dac_buf !== '0) begin
      errors++;
      $display("FAIL R1: actual code=%h en=%b expected 0 0", dac_code, out_en);
    end
    chk("R1");

    // asynchronous sweep, all channels, varied fields (R3 R4 R5 R8)
    for (int ch = 0; ch < 4; ch++) begin
      for (int k = 0; k < 5; k++) begin
        int code;
        code = (k * 341 + ch * 37 + 1) % 1024;
        wr(ch, code, k[0], k[1], k != 3, 1'b1);
        chk("R3 held after async write");
        ldac_n = 1'b0; step();
        chk("R4 R8 async move");
        wr((ch + 1) % 4, 1023 - code, k[1], k[0], 1'b1, 1'b1);
        chk("R3 held while low");
        ldac_n = 1'b1; step();
        ldac_n = 1'b0; step();
        chk("R5 R4 other channels kept");
        ldac_n = 1'b1; step();
      end
    end

    // R2: strobe without byte pulse
    wr(2, 777, 1, 1, 1, 1'b0);
    ldac_n = 1'b0; step(); ldac_n = 1'b1; step();
    chk("R2 no commit without byte_tick");

    // R11: commit coincides with falling ldac_n
    wr(0, 100, 0, 0, 1, 1'b1);
    ldac_n = 1'b0;
    wr(0, 200, 1, 1, 1, 1'b1);
    chk("R11 old word moved");
    ldac_n = 1'b1; step();
    ldac_n = 1'b0; step();
    chk("R11 pending word moved");
    ldac_n = 1'b1; step();

    // R9 R10 power-down
    pd_n = 1'b0; #1;
    chk("R9 pin low");
    wr(3, 512, 1, 0, 1, 1'b1);
    ldac_n = 1'b0; step(); ldac_n = 1'b1; step();
    chk("R10 update while down");
    pd_n = 1'b1; #1;
    chk("R10 R9 exit presents codes");
    checks++;
    if (dac_code[39:30] !== 10'd512 || out_en[3] !== 1'b1) begin
      errors++;
      $display("FAIL R10: actual %h/%b expected 200/1", dac_code[39:30], out_en[3]);
    end

    // synchronous mode (R6 R7)
    sync_mode = 1'b1; step();
    ldac_n = 1'b0; step();
    for (int ch = 0; ch < 4; ch++) begin
      for (int k = 0; k < 4; k++) begin
        wr(ch, (ch * 256 + k * 85) % 1024, k[0], ~k[0], 1'b1, 1'b1);
        chk("R6 sync direct");
      end
    end
    ldac_n = 1'b1; step();
    for (int ch = 0; ch < 4; ch++) begin
      wr(ch, 1000 - ch * 111, 1, 1, ch != 2, 1'b1);
      chk("R7 held while high");
    end
    ldac_n = 1'b0; step();
    chk("R7 level move");
    ldac_n = 1'b1; step();
    chk("R7 settled");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule